// File: doc/BRIEF.md
# Subtract-and-Branch One-Instruction Processor

This block is a minimal processor that knows a single instruction. Each instruction is three consecutive memory words: a source address, a destination address and a branch target. The processor reads the word at the source, reads the word at the destination, and stores the destination minus the source back into the destination. If that stored value is zero or negative, control passes to the target. Otherwise execution moves on to the next three-word instruction. Clearing a cell, an unconditional jump and addition through a scratch zero cell are all written as short chains of this one operation.

The core holds the program counter, three latched operand fields, the latched source value and a sequencing state machine. It drives one single-port synchronous memory with a one-cycle read latency, and that memory holds both code and data. A pulse on `start` runs the program from word 0. A taken branch to the all-ones address stops the core and raises `halted`.

Top module: `sbp_core`

## Requirements
- R1: After reset the core is idle, with `halted` low and `mem_we` low. A `start` pulse while idle or halted begins execution at word 0. `start` is ignored while a program is running.
- R2: An instruction writes Mem[b] - Mem[a] into Mem[b], using 16-bit two's-complement wraparound. Mem[a] is left unchanged when a differs from b.
- R3: The fields of the instruction at PC are read from PC (a), PC+1 (b) and PC+2 (target). Only the low AW bits (8 by default) of each field form the address, and the upper bits are ignored.
- R4: When the stored result is positive (bit 15 clear and nonzero), the next instruction starts at PC+3.
- R5: When the stored result is zero or has bit 15 set, the next instruction starts at the target. This includes 0 and -32768.
- R6: A taken branch whose target is the all-ones address (255) moves the core to halted. `halted` then stays high, with no memory writes, until the next `start`. A not-taken instruction with that target does not halt.
- R7: An instruction whose a and b are the same address clears that word to zero and always branches.
- R8: Each instruction takes exactly 7 clock cycles and makes exactly one memory write. A run of N instructions raises `halted` 7*N cycles after the edge that samples `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Begin execution at word 0 when idle or halted |
| halted | output | 1 | High after a taken branch to the all-ones address |
| mem_addr | output | AW (8) | Memory word address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | DW (16) | Memory write data |
| mem_rdata | input | DW (16) | Memory read data, valid one cycle after the address |

## Verification
The write-back and the branch decision both come from the same subtraction. A single instruction therefore both stores a value and chooses whether to fall through, jump, or halt. The bench sweeps every pair from a set of boundary operands through a one-instruction template. For each pair it checks the stored word against the difference it computes itself. It also checks the path taken, using the cycle count, which differs by a full instruction between the two paths. Separate programs give a halting target to an instruction whose result is positive, and give identical operand addresses to the clearing case. In both, the write and the halt-or-branch decision fall in the same instruction.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_FA,
    S_FB,
    S_FT,
    S_RA,
    S_RB,
    S_WR,
    S_UP,
    S_HALT
  } sbp_state_e;
endpackage

// File: rtl/sbp_alu.sv
module sbp_alu #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] minuend,
  input  logic [DW-1:0] subtrahend,
  output logic [DW-1:0] diff,
  output logic          leq
);
  always_comb begin
    diff = minuend - subtrahend;
    leq  = diff[DW-1] | (diff == '0);
  end
endmodule

// File: rtl/sbp_ctrl.sv
module sbp_ctrl
  import sbp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       leq_q,
  input  logic       halt_tgt,
  output sbp_state_e state
);
  sbp_state_e state_nxt;

  always_comb begin
    state_nxt = state;
    unique case (state)
      S_IDLE, S_HALT: if (start) state_nxt = S_FA;
      S_FA:           state_nxt = S_FB;
      S_FB:           state_nxt = S_FT;
      S_FT:           state_nxt = S_RA;
      S_RA:           state_nxt = S_RB;
      S_RB:           state_nxt = S_WR;
      S_WR:           state_nxt = S_UP;
      S_UP:           state_nxt = (leq_q && halt_tgt) ? S_HALT : S_FA;
      default:        state_nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= state_nxt;
  end

  // R6: once halted, the core stays halted until start
  a_r6_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HALT && !start) |=> (state == S_HALT));
  // R1: start during a run does not restart the sequence
  a_r1_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FB) |=> (state == S_FT));
endmodule

// File: rtl/sbp_core.sv
module sbp_core
  import sbp_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          halted,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  localparam logic [AW-1:0] HALT_ADDR = '1;
  localparam logic [AW-1:0] STEP      = AW'(3);

  sbp_state_e    state;
  logic [AW-1:0] pc, a_ad, b_ad, tgt;
  logic [AW-1:0] pc_nxt;
  logic [DW-1:0] opa;
  logic [DW-1:0] diff;
  logic          leq, leq_q;
  logic          pc_en, a_en, b_en, t_en, opa_en, leq_en;

  sbp_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .leq_q    (leq_q),
    .halt_tgt (tgt == HALT_ADDR),
    .state    (state)
  );

  sbp_alu #(.DW(DW)) u_alu (
    .minuend    (mem_rdata),
    .subtrahend (opa),
    .diff       (diff),
    .leq        (leq)
  );

  always_comb begin
    a_en   = (state == S_FB);
    b_en   = (state == S_FT);
    t_en   = (state == S_RA);
    opa_en = (state == S_RB);
    leq_en = (state == S_WR);
    pc_en  = ((state == S_IDLE || state == S_HALT) && start) || (state == S_UP);
    if (state == S_UP) pc_nxt = leq_q ? tgt : pc + STEP;
    else               pc_nxt = '0;
  end

  always_comb begin
    mem_we    = (state == S_WR);
    mem_wdata = diff;
    halted    = (state == S_HALT);
    unique case (state)
      S_FA:       mem_addr = pc;
      S_FB:       mem_addr = pc + AW'(1);
      S_FT:       mem_addr = pc + AW'(2);
      S_RA:       mem_addr = a_ad;
      S_RB, S_WR: mem_addr = b_ad;
      default:    mem_addr = pc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc    <= '0;
      a_ad  <= '0;
      b_ad  <= '0;
      tgt   <= '0;
      opa   <= '0;
      leq_q <= 1'b0;
    end else begin
      if (pc_en)  pc    <= pc_nxt;
      if (a_en)   a_ad  <= mem_rdata[AW-1:0];
      if (b_en)   b_ad  <= mem_rdata[AW-1:0];
      if (t_en)   tgt   <= mem_rdata[AW-1:0];
      if (opa_en) opa   <= mem_rdata;
      if (leq_en) leq_q <= leq;
    end
  end

  // R8: one write per instruction, never back to back
  a_r8_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
  // R2: write goes to the address whose value was just read as Mem[b]
  a_r2_write_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr == $past(mem_addr)));
  // R6: no writes while halted
  a_r6_no_write_halted: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we);
  // R4: positive result falls through to PC+3
  a_r4_fall_through: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_UP && !leq_q) |=> (pc == $past(pc) + STEP));
  // R5: zero or negative result goes to the target
  a_r5_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_UP && leq_q && tgt != HALT_ADDR) |=> (pc == $past(tgt)));
endmodule

// File: tb/tb_sbp_core.sv
`timescale 1ns/1ps
module tb_sbp_core;
  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic          halted;
  logic [AW-1:0] mem_addr;
  logic          mem_we;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;

  logic [DW-1:0] mem [0:(1<<AW)-1];
  int checks;
  int fails;
  int wr_cnt;
  int cyc;
  bit mid_start;

  sbp_core #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .halted(halted),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < (1<<AW); i++) mem[i] = '0;
  endtask

  task automatic put(input int at, input logic [DW-1:0] a,
                     input logic [DW-1:0] b, input logic [DW-1:0] t);
    mem[at] = a; mem[at+1] = b; mem[at+2] = t;
  endtask

  // pulse start, count cycles until halted; returns count (-1 on timeout)
  task automatic run(output int n);
    @(negedge clk);
    wr_cnt = 0;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    n = 0;
    for (int k = 0; k < 2000; k++) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (mid_start && n == 3) start = 1'b1;
      else start = 1'b0;
      if (halted) break;
    end
    start = 1'b0;
    if (!halted) begin
      chk(1'b0, "R8", "watchdog run timeout", n, 0);
      n = -1;
    end
  endtask

  initial begin
    int n;
    logic [DW-1:0] vals [8];
    logic [DW-1:0] r;
    bit taken;
    checks = 0; fails = 0; wr_cnt = 0; mid_start = 1'b0;
    start = 1'b0;
    rst_n = 1'b0;
    clear_mem();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(!halted, "R1", "halted after reset", halted, 0);
      chk(!mem_we, "R1", "mem_we after reset", mem_we, 0);
    end

    vals[0] = 16'd0;    vals[1] = 16'd1;    vals[2] = 16'hFFFF; vals[3] = 16'd2;
    vals[4] = 16'h7FFF; vals[5] = 16'h8000; vals[6] = 16'h4000; vals[7] = 16'hFFFB;

    // R2 R3 R4 R5: sweep of operand pairs through one instruction
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        clear_mem();
        put(0, 16'hAB64, 16'h5C65, 16'h0006); // a=100, b=101 (upper bits junk)
        put(3, 16'd102, 16'd102, 16'd6);     // jump to 6
        put(6, 16'd102, 16'd102, 16'h00FF);  // halt
        mem[100] = vals[i];
        mem[101] = vals[j];
        r = vals[j] - vals[i];
        taken = (r == 16'd0) || r[15];
        run(n);
        chk(mem[101] == r, "R2", "Mem[b]", mem[101], r);
        chk(mem[100] == vals[i], "R2", "Mem[a] kept", mem[100], vals[i]);
        if (taken) chk(n == 14, "R5", "cycles taken", n, 14);
        else       chk(n == 21, "R4", "cycles fall", n, 21);
        chk(wr_cnt == (taken ? 2 : 3), "R8", "writes", wr_cnt, taken ? 2 : 3);
      end
    end

    // R7: a == b clears and branches
    clear_mem();
    put(0, 16'd100, 16'd100, 16'd6);
    put(3, 16'd102, 16'd102, 16'd6);
    put(6, 16'd102, 16'd102, 16'h00FF);
    mem[100] = 16'h1234;
    run(n);
    chk(mem[100] == 16'd0, "R7", "cleared cell", mem[100], 0);
    chk(n == 14, "R7", "clear branches", n, 14);

    // R6: halting target with positive result does not halt
    clear_mem();
    put(0, 16'd100, 16'd101, 16'h00FF);
    put(3, 16'd102, 16'd102, 16'h00FF);
    mem[100] = 16'd2; mem[101] = 16'd5;
    run(n);
    chk(mem[101] == 16'd3, "R6", "result before halt", mem[101], 3);
    chk(n == 14, "R6", "no halt on positive", n, 14);

    // R6: halted holds, no writes
    wr_cnt = 0;
    repeat (20) @(negedge clk);
    chk(halted, "R6", "halted holds", halted, 1);
    chk(wr_cnt == 0, "R6", "no writes halted", wr_cnt, 0);
    chk(mem[101] == 16'd3, "R6", "memory unchanged halted", mem[101], 3);

    // unconditional jump skips instruction at 3 (R5)
    clear_mem();
    put(0, 16'd102, 16'd102, 16'd9);
    put(3, 16'd100, 16'd100, 16'h00FF);
    put(9, 16'd102, 16'd102, 16'h00FF);
    mem[100] = 16'd5;
    run(n);
    chk(mem[100] == 16'd5, "R5", "jump skipped cell", mem[100], 5);
    chk(n == 14, "R5", "jump cycles", n, 14);

    // R2 R8: addition via scratch Z, with a mid-run start for R1
    for (int i = 0; i < 8; i++) begin
      clear_mem();
      put(0, 16'd100, 16'd102, 16'd3);
      put(3, 16'd102, 16'd101, 16'd6);
      put(6, 16'd102, 16'd102, 16'd9);
      put(9, 16'd102, 16'd102, 16'h00FF);
      mem[100] = vals[i];
      mem[101] = vals[7 - i];
      mid_start = (i % 2 == 1);
      run(n);
      mid_start = 1'b0;
      r = vals[i] + vals[7 - i];
      chk(mem[101] == r, "R2", "sum", mem[101], r);
      chk(mem[102] == 16'd0, "R2", "Z cleared", mem[102], 0);
      chk(n == 28, "R8", "add cycles", n, 28);
      chk(n == 28, "R1", "start ignored mid-run", n, 28);
      chk(wr_cnt == 4, "R8", "add writes", wr_cnt, 4);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    fails++;
    checks++;
    $display("FAIL R8 global watchdog: actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule